// File: doc/BRIEF.md
# Two-Link Multiplexed Transmit Bus Splitter

The block takes a single high-speed transmit bus that carries byte-interleaved data for two T1/E1 links. It delivers each link's bytes, with their signaling nibbles, as separate strobed streams. The bus runs at 8.192 Mb/s, which gives 128 byte slots in each 125 µs frame. A shared bit clock, frame pulse and signaling line serve both links. The bus clock is presented to the block as a one-cycle `bus_tick` strobe for each active edge. In double-rate mode there are two ticks per bit: the frame pulse is taken on the first tick, and a mode bit picks which tick samples data and signaling.

Each link has its own channel offset. Link A's byte k sits in slot (offset_a + 2k) mod 128, and the same rule applies to link B with offset_b. Both links follow one shared copy of the mode settings: clock rate, data edge, frame-pulse lead and frame-pulse polarity. Two offsets that would place both links on the same slots raise a configuration error, and link B is then silenced. A sticky alignment error records any frame pulse that is not a whole number of frames after the previous one. That error can drive an interrupt.

Top module: `mux_bus_splitter`

## Requirements
- R1: After reset, `lnk_vld`, `lnk_fstart`, `lnk_idx`, `lnk_data`, `lnk_sig`, `align_err` and `irq` are all zero. With offsets of unequal parity, `cfg_err` is also zero.
- R2: No byte is delivered on either link before the first active frame pulse after reset.
- R3: Without lead, the tick that carries the active frame pulse is the first tick of bit 0 of slot 0. Slot s holds frame bits 8s to 8s+7, and the first bit received is the byte's MSB (bit 7).
- R4: The link with offset o delivers the byte of slot (o + 2k) mod 128 with `lnk_idx` = k (0..63). It raises `lnk_fstart` together with `lnk_vld` exactly when k = 0.
- R5: The signaling nibble of a byte is the signaling line sampled at bit positions 4 to 7 of that slot, MSB first. The line's value at positions 0 to 3 has no effect.
- R6: With `cfg_fp_inv` = 0 the frame pulse is active high. With `cfg_fp_inv` = 1 it is active low.
- R7: With `cfg_fp_lead` = 1 the active frame pulse is sampled one tick before the first tick of bit 0. In that tick the pulse is the last tick of the previous frame.
- R8: With `cfg_dbl_rate` = 1 each bit spans two ticks. Data and signaling are taken on the first tick when `cfg_data_edge` = 0 and on the second tick when it is 1.
- R9: When the two offsets have equal parity (bit 0 equal), `cfg_err` is 1 and link B delivers nothing. Link A keeps working.
- R10: An active frame pulse that arrives after sync at any tick other than a frame boundary sets `align_err`. The error stays set until reset. Pulses that come one or more whole frames apart leave it clear.
- R11: `irq` is 1 exactly when `align_err` and `cfg_irq_en` are both 1.
- R12: Each completed slot gives at most one link a one-cycle `lnk_vld` pulse, in the clock cycle after the tick that carried the slot's last bit. `lnk_vld` is never 2'b11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_tick | input | 1 | One-cycle strobe per active bus clock edge |
| bus_fp | input | 1 | Shared frame pulse |
| bus_data | input | 1 | Serial multiplexed data |
| bus_sig | input | 1 | Serial signaling, aligned per channel with data |
| cfg_dbl_rate | input | 1 | 1: two ticks per bit |
| cfg_data_edge | input | 1 | In double rate, selects the data tick (0 first, 1 second) |
| cfg_fp_lead | input | 1 | 1: frame pulse comes one tick ahead of bit 0 |
| cfg_fp_inv | input | 1 | 1: frame pulse is active low |
| cfg_irq_en | input | 1 | Enables `irq` from the alignment error |
| cfg_off_a | input | 7 | Channel offset of link A |
| cfg_off_b | input | 7 | Channel offset of link B |
| lnk_vld | output | 2 | Byte strobe per link (bit 0 = A) |
| lnk_fstart | output | 2 | Frame start strobe per link (byte index 0) |
| lnk_idx | output | 2x6 | Byte index within the link's frame |
| lnk_data | output | 2x8 | Byte per link |
| lnk_sig | output | 2x4 | Signaling nibble per link |
| cfg_err | output | 1 | Offsets collide (equal parity) |
| align_err | output | 1 | Sticky frame-pulse spacing error |
| irq | output | 1 | Interrupt request |

## Verification
Every frame carries a byte and nibble pattern that depends on slot and frame number, so a byte delivered from the wrong slot or the wrong frame cannot match. Offset pairs 0/1 and 10/77 separate a correct modulo-128 slot mapping from a plain addition, and a 3/5 pair tests the collision path. In double-rate mode the unselected tick carries the inverted bit, so sampling on the wrong edge returns wrong values. Frame pulses on every frame and on every second frame are checked to leave the alignment error clear. A pulse after a truncated frame is checked to set it, and the same runs cover inverted and leading pulses.

// File: rtl/mxd_pkg.sv
package mxd_pkg;

  localparam int NLINK = 2;

  typedef struct packed {
    logic dbl;
    logic dedge;
    logic fp_lead;
    logic fp_inv;
  } mxd_mode_t;

  // bit number carried by a tick index
  function automatic int unsigned tick_bit(int unsigned t, logic dbl);
    return dbl ? (t >> 1) : t;
  endfunction

  // whether a tick index is a data-sampling tick
  function automatic logic phase_ok(int unsigned t, logic dbl, logic dedge);
    return !dbl || (t[0] == dedge);
  endfunction

  // slot distance from a link's offset, modulo the slot count
  function automatic int unsigned rel_slot(int unsigned slot, int unsigned off,
                                           int unsigned slots);
    return (slot + slots - off) % slots;
  endfunction

endpackage

// File: rtl/mxd_timing.sv
module mxd_timing
  import mxd_pkg::*;
#(
  parameter int SLOTS = 128,
  localparam int BITS = SLOTS * 8,
  localparam int TW = $clog2(BITS * 2),
  localparam int BW = $clog2(BITS)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tick,
  input  logic            fp_in,
  input  mxd_mode_t       mode,
  output logic            samp,
  output logic [BW-1:0]   bit_idx,
  output logic            synced,
  output logic            align_err
);

  logic [TW-1:0] pos;
  logic [TW-1:0] last_t;
  logic [TW-1:0] exp_t;
  logic [TW-1:0] cur_t;
  logic          fp_act;
  logic          misaligned;

  assign fp_act     = tick && (fp_in ^ mode.fp_inv);
  assign last_t     = mode.dbl ? TW'(BITS * 2 - 1) : TW'(BITS - 1);
  assign exp_t      = mode.fp_lead ? last_t : '0;
  assign cur_t      = fp_act ? exp_t : pos;
  assign misaligned = fp_act && synced && (pos != exp_t);
  assign samp       = tick && (synced || (fp_act && !mode.fp_lead))
                      && phase_ok(32'(cur_t), mode.dbl, mode.dedge);
  assign bit_idx    = BW'(tick_bit(32'(cur_t), mode.dbl));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos       <= '0;
      synced    <= 1'b0;
      align_err <= 1'b0;
    end else if (tick) begin
      pos <= (cur_t == last_t) ? '0 : cur_t + 1'b1;
      if (fp_act)     synced    <= 1'b1;
      if (misaligned) align_err <= 1'b1;
    end
  end

  assert_misalign_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
    misaligned |=> align_err);
  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    align_err |=> align_err);

endmodule

// File: rtl/mxd_shift.sv
module mxd_shift #(
  parameter int SLOTS = 128,
  localparam int BITS = SLOTS * 8,
  localparam int BW = $clog2(BITS),
  localparam int SW = $clog2(SLOTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          samp,
  input  logic [BW-1:0] bit_idx,
  input  logic          d,
  input  logic          s,
  output logic          done,
  output logic [SW-1:0] slot,
  output logic [7:0]    byte_q,
  output logic [3:0]    sig_q
);

  logic [6:0] sh;
  logic [2:0] sg;
  logic [2:0] bpos;

  assign bpos = bit_idx[2:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh     <= '0;
      sg     <= '0;
      done   <= 1'b0;
      slot   <= '0;
      byte_q <= '0;
      sig_q  <= '0;
    end else begin
      done <= 1'b0;
      if (samp) begin
        sh <= {sh[5:0], d};
        if (bpos[2]) sg <= {sg[1:0], s};
        if (bpos == 3'd7) begin
          done   <= 1'b1;
          byte_q <= {sh, d};
          sig_q  <= {sg, s};
          slot   <= bit_idx[BW-1:3];
        end
      end
    end
  end

  assert_done_after_sample_R12: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(samp));

endmodule

// File: rtl/mux_bus_splitter.sv
module mux_bus_splitter
  import mxd_pkg::*;
#(
  parameter int SLOTS = 128
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            bus_tick,
  input  logic                            bus_fp,
  input  logic                            bus_data,
  input  logic                            bus_sig,
  input  logic                            cfg_dbl_rate,
  input  logic                            cfg_data_edge,
  input  logic                            cfg_fp_lead,
  input  logic                            cfg_fp_inv,
  input  logic                            cfg_irq_en,
  input  logic [$clog2(SLOTS)-1:0]        cfg_off_a,
  input  logic [$clog2(SLOTS)-1:0]        cfg_off_b,
  output logic [1:0]                      lnk_vld,
  output logic [1:0]                      lnk_fstart,
  output logic [1:0][$clog2(SLOTS)-2:0]   lnk_idx,
  output logic [1:0][7:0]                 lnk_data,
  output logic [1:0][3:0]                 lnk_sig,
  output logic                            cfg_err,
  output logic                            align_err,
  output logic                            irq
);

  localparam int BW = $clog2(SLOTS * 8);
  localparam int SW = $clog2(SLOTS);
  localparam int IW = SW - 1;

  mxd_mode_t     mode;
  logic          samp;
  logic [BW-1:0] bit_idx;
  logic          synced;
  logic          done;
  logic [SW-1:0] slot;
  logic [7:0]    byte_q;
  logic [3:0]    sig_q;

  assign mode = '{dbl: cfg_dbl_rate, dedge: cfg_data_edge,
                  fp_lead: cfg_fp_lead, fp_inv: cfg_fp_inv};

  mxd_timing #(.SLOTS(SLOTS)) u_timing (
    .clk(clk), .rst_n(rst_n), .tick(bus_tick), .fp_in(bus_fp), .mode(mode),
    .samp(samp), .bit_idx(bit_idx), .synced(synced), .align_err(align_err)
  );

  mxd_shift #(.SLOTS(SLOTS)) u_shift (
    .clk(clk), .rst_n(rst_n), .samp(samp), .bit_idx(bit_idx),
    .d(bus_data), .s(bus_sig), .done(done), .slot(slot),
    .byte_q(byte_q), .sig_q(sig_q)
  );

  assign cfg_err = (cfg_off_a[0] == cfg_off_b[0]);
  assign irq     = align_err && cfg_irq_en;

  for (genvar i = 0; i < NLINK; i++) begin : g_link
    logic [SW-1:0] off;
    logic [31:0]   rel;
    logic          own;
    assign off = (i == 0) ? cfg_off_a : cfg_off_b;
    always_comb begin
      rel = rel_slot(32'(slot), 32'(off), SLOTS);
      own = done && !rel[0] && ((i == 0) || !cfg_err);
    end
    assign lnk_vld[i]    = own;
    assign lnk_idx[i]    = own ? IW'(rel >> 1) : '0;
    assign lnk_data[i]   = own ? byte_q : '0;
    assign lnk_sig[i]    = own ? sig_q : '0;
    assign lnk_fstart[i] = own && (rel == 32'd0);
  end

  assert_one_link_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lnk_vld));
  assert_vld_follows_tick_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (lnk_vld != 2'b00) |-> $past(bus_tick));
  assert_no_output_unsynced_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !synced |-> (lnk_vld == 2'b00));
  assert_collision_mutes_b_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_err |-> !lnk_vld[1]);
  assert_fstart_a_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lnk_fstart[0] |-> (lnk_vld[0] && lnk_idx[0] == '0));
  assert_fstart_b_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lnk_fstart[1] |-> (lnk_vld[1] && lnk_idx[1] == '0));

endmodule

// File: tb/mux_bus_splitter_bench.sv
module mux_bus_splitter_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_tick = 1'b0, bus_fp = 1'b0, bus_data = 1'b0, bus_sig = 1'b0;
  logic cfg_dbl_rate = 1'b0, cfg_data_edge = 1'b0, cfg_fp_lead = 1'b0;
  logic cfg_fp_inv = 1'b0, cfg_irq_en = 1'b0;
  logic [6:0] cfg_off_a = 7'd0, cfg_off_b = 7'd1;
  logic [1:0] lnk_vld, lnk_fstart;
  logic [1:0][5:0] lnk_idx;
  logic [1:0][7:0] lnk_data;
  logic [1:0][3:0] lnk_sig;
  logic cfg_err, align_err, irq;

  int checks = 0, failures = 0;
  int cur_frame = 0;
  int mcnt[2], mbad[2], mfst[2];
  int both_cnt = 0;

  always #5 clk = ~clk;

  mux_bus_splitter u_mux_bus_splitter (
    .clk(clk), .rst_n(rst_n), .bus_tick(bus_tick), .bus_fp(bus_fp),
    .bus_data(bus_data), .bus_sig(bus_sig), .cfg_dbl_rate(cfg_dbl_rate),
    .cfg_data_edge(cfg_data_edge), .cfg_fp_lead(cfg_fp_lead),
    .cfg_fp_inv(cfg_fp_inv), .cfg_irq_en(cfg_irq_en), .cfg_off_a(cfg_off_a),
    .cfg_off_b(cfg_off_b), .lnk_vld(lnk_vld), .lnk_fstart(lnk_fstart),
    .lnk_idx(lnk_idx), .lnk_data(lnk_data), .lnk_sig(lnk_sig),
    .cfg_err(cfg_err), .align_err(align_err), .irq(irq)
  );

  function automatic logic [7:0] pat(int s, int f);
    return 8'((s * 37 + f * 11 + 5) % 256);
  endfunction

  function automatic logic [3:0] nib(int s, int f);
    return 4'((s * 5 + f * 3 + 9) % 16);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor: compares every delivered byte against the slot rule (R3 R4 R5)
  always @(negedge clk) begin
    int s;
    if (rst_n) begin
      if (lnk_vld == 2'b11) both_cnt++;
      for (int l = 0; l < 2; l++) begin
        if (lnk_vld[l]) begin
          s = ((l == 0 ? int'(cfg_off_a) : int'(cfg_off_b)) + 2 * int'(lnk_idx[l])) % 128;
          mcnt[l]++;
          if (lnk_data[l] != pat(s, cur_frame) || lnk_sig[l] != nib(s, cur_frame))
            mbad[l]++;
          if (lnk_fstart[l] != (lnk_idx[l] == 6'd0)) mbad[l]++;
          if (lnk_fstart[l]) mfst[l]++;
        end
      end
    end
  end

  task automatic clear_mon();
    for (int l = 0; l < 2; l++) begin
      mcnt[l] = 0; mbad[l] = 0; mfst[l] = 0;
    end
    both_cnt = 0;
  endtask

  task automatic do_reset(bit dbl, bit dedge, bit lead, bit inv, int oa, int ob);
    @(negedge clk);
    rst_n = 1'b0;
    bus_tick = 1'b0;
    bus_fp = inv;
    cfg_dbl_rate = dbl; cfg_data_edge = dedge; cfg_fp_lead = lead;
    cfg_fp_inv = inv; cfg_off_a = 7'(oa); cfg_off_b = 7'(ob);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    clear_mon();
  endtask

  task automatic send_tick(bit fpa, bit d, bit s);
    @(negedge clk);
    bus_tick = 1'b1;
    bus_fp = fpa ^ cfg_fp_inv;
    bus_data = d;
    bus_sig = s;
    @(negedge clk);
    bus_tick = 1'b0;
  endtask

  // sends one frame of frame number f; nticks < 0 means the whole frame
  task automatic do_frame(int f, bit pulse, int nticks);
    int nph, total, t;
    bit v, sv, fpa;
    nph = cfg_dbl_rate ? 2 : 1;
    total = 1024 * nph;
    if (nticks >= 0) total = nticks;
    cur_frame = f;
    t = 0;
    for (int b = 0; b < 1024; b++) begin
      for (int ph = 0; ph < nph; ph++) begin
        if (t < total) begin
          v = pat(b / 8, f)[7 - (b % 8)];
          sv = ((b % 8) >= 4) ? nib(b / 8, f)[7 - (b % 8)] : 1'b1;
          if (cfg_dbl_rate && (ph != int'(cfg_data_edge))) begin
            v = ~v; sv = ~sv;
          end
          fpa = pulse && (cfg_fp_lead ? (t == 1024 * nph - 1) : (t == 0));
          send_tick(fpa, v, sv);
        end
        t++;
      end
    end
    @(negedge clk);
  endtask

  task automatic frame_check(string req, int f, bit pulse, int ea, int eb);
    clear_mon();
    do_frame(f, pulse, -1);
    chk({req, " link A byte count"}, mcnt[0], ea);
    chk({req, " link B byte count"}, mcnt[1], eb);
    chk({req, " link A mismatches"}, mbad[0], 0);
    chk({req, " link B mismatches"}, mbad[1], 0);
    chk({req, " link A frame starts"}, mfst[0], ea > 0 ? 1 : 0);
    chk({req, " link B frame starts"}, mfst[1], eb > 0 ? 1 : 0);
    chk("R12 never both links", both_cnt, 0);
  endtask

  task automatic t_reset();
    do_reset(0, 0, 0, 0, 0, 1);
    @(negedge clk);
    chk("R1 vld idle", int'(lnk_vld), 0);
    chk("R1 fstart idle", int'(lnk_fstart), 0);
    chk("R1 data zero", int'(lnk_data), 0);
    chk("R1 idx/sig zero", int'(lnk_idx) + int'(lnk_sig), 0);
    chk("R1 cfg_err clear", int'(cfg_err), 0);
    chk("R1 align_err clear", int'(align_err), 0);
    chk("R1 irq clear", int'(irq), 0);
  endtask

  task automatic t_nopulse();
    do_reset(0, 0, 0, 0, 0, 1);
    frame_check("R2 before sync", 1, 0, 0, 0);
  endtask

  task automatic t_basic();
    do_reset(0, 0, 0, 0, 0, 1);
    frame_check("R3 R4 R5 offsets 0/1 frame 2", 2, 1, 64, 64);
    frame_check("R3 R4 R5 offsets 0/1 frame 3", 3, 1, 64, 64);
    chk("R10 pulses every frame keep align_err clear", int'(align_err), 0);
  endtask

  task automatic t_offsets();
    do_reset(0, 0, 0, 0, 10, 77);
    frame_check("R4 offsets 10/77 wrap", 4, 1, 64, 64);
  endtask

  task automatic t_inv();
    do_reset(0, 0, 0, 1, 6, 3);
    frame_check("R6 active-low pulse", 5, 1, 64, 64);
  endtask

  task automatic t_lead();
    do_reset(0, 0, 1, 0, 0, 1);
    frame_check("R7 lead sync frame", 6, 1, 0, 0);
    frame_check("R7 lead data frame", 7, 1, 64, 64);
    chk("R7 lead pulses keep align_err clear", int'(align_err), 0);
  endtask

  task automatic t_dbl();
    do_reset(1, 0, 0, 0, 2, 9);
    frame_check("R8 double rate first edge", 8, 1, 64, 64);
    do_reset(1, 1, 0, 0, 2, 9);
    frame_check("R8 double rate second edge", 9, 1, 64, 64);
    chk("R8 double rate align_err clear", int'(align_err), 0);
  endtask

  task automatic t_collide();
    do_reset(0, 0, 0, 0, 3, 5);
    @(negedge clk);
    chk("R9 cfg_err on equal parity", int'(cfg_err), 1);
    frame_check("R9 link B muted", 10, 1, 64, 0);
  endtask

  task automatic t_align();
    do_reset(0, 0, 0, 0, 0, 1);
    cfg_irq_en = 1'b1;
    do_frame(11, 1, -1);
    do_frame(12, 0, -1);
    do_frame(13, 1, -1);
    chk("R10 pulse two frames apart keeps clear", int'(align_err), 0);
    chk("R11 irq low with no error", int'(irq), 0);
    do_frame(14, 0, 100);
    do_frame(15, 1, -1);
    chk("R10 misplaced pulse sets align_err", int'(align_err), 1);
    chk("R11 irq with enable", int'(irq), 1);
    do_frame(16, 1, -1);
    chk("R10 align_err stays set", int'(align_err), 1);
    cfg_irq_en = 1'b0;
    @(negedge clk);
    chk("R11 irq masked", int'(irq), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_nopulse();
    t_basic();
    t_offsets();
    t_inv();
    t_lead();
    t_dbl();
    t_collide();
    t_align();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule